// File: doc/BRIEF.md
# Receive Character Queue with Per-Character Status

This block sits between a serial receiver core and the host side of a UART. Each character the receiver delivers is stored together with its break, framing-error and parity-error flags in a sixteen-entry first-in first-out store. The host sees the oldest stored character and its flags on the status outputs. It removes that character with a one-cycle pop strobe. An active-high flag tells the host that no character is waiting.

The block also raises the receive interrupt. This happens when the fill reaches a selectable trigger level, or when characters have waited too long with no traffic. A separate output tells the far end whether it may keep sending, based on a programmable fill threshold. When a character arrives with the store full, it is not lost. It waits in a holding stage and enters the store at the next pop. The overrun is flagged on the character currently at the head.

Top module: `uart_rx_fifo_stat`

## Requirements
- R1: The store holds up to 16 characters, delivered in arrival order. `fill_cnt` (5 bits) gives the number stored. A `rx_valid` strobe adds one character. A `pop` strobe removes the head.
- R2: The break, framing and parity flags of a character travel with it. `head_data`, `st_brk`, `st_ferr`, `st_perr` and `st_ovr` show the head character. All of them read 0 while the store is empty.
- R3: `st_empty` reads 1 exactly when no character is stored. A pop while empty has no effect.
- R4: If a character arrives while the store is full and no pop is made, it is kept in a holding stage. `st_ovr` of the current head is set, and the held character enters the store at the next pop, after the 16 already stored. Arrivals while a character is already held are dropped.
- R5: `trig_sel` selects the trigger level: 00 = 1, 01 = 4, 10 = 8, 11 = 12 characters. `st_rdis` becomes 1 one cycle after `fill_cnt` first reaches the level.
- R6: `st_rdis` and `st_tout` are sticky. A `clr_rdis` or `clr_tout` pulse (a 0 written to the bit) clears them. `st_rdis` sets again if the fill is still at or above the level.
- R7: `st_tout` sets when the store is non-empty and 4 × `TICKS_PER_CHAR` (default 40) `baud_tick` pulses pass with no push or pop. Any push or pop restarts the count.
- R8: `irq` is 1 when `rx_ie` is 1 and either `st_rdis` or `st_tout` is 1. Otherwise it is 0.
- R9: The store and the holding stage are emptied only when `fifo_rst` and `rst_en` are both 1 in the same cycle. `fifo_rst` alone has no effect.
- R10: The send-permission threshold resets to 15 and is loaded from `rts_wdata` when `rts_we` is 1. `flow_go` is 1 while `fill_cnt` is below the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receiver delivers a character |
| rx_data | input | 8 | Received character |
| rx_brk | input | 1 | Break seen on this character |
| rx_ferr | input | 1 | Framing error on this character |
| rx_perr | input | 1 | Parity error on this character |
| pop | input | 1 | Host removes the head character |
| baud_tick | input | 1 | One pulse per bit time |
| trig_sel | input | 2 | Trigger level code |
| rx_ie | input | 1 | Receive interrupt enable |
| clr_rdis | input | 1 | Clear trigger status |
| clr_tout | input | 1 | Clear timeout status |
| fifo_rst | input | 1 | Request store flush |
| rst_en | input | 1 | Enables the flush request |
| rts_we | input | 1 | Load threshold |
| rts_wdata | input | 4 | New threshold |
| head_data | output | 8 | Head character |
| st_brk | output | 1 | Head break flag |
| st_ferr | output | 1 | Head framing flag |
| st_perr | output | 1 | Head parity flag |
| st_ovr | output | 1 | Overrun flagged on head |
| st_empty | output | 1 | No character available |
| fill_cnt | output | 5 | Stored character count |
| st_rdis | output | 1 | Trigger level reached (sticky) |
| st_tout | output | 1 | Receive timeout (sticky) |
| irq | output | 1 | Receive interrupt request |
| flow_go | output | 1 | Far end may keep sending |

## Verification
The hardest state to reach from the ports is the overrun path. The store must be completely full, a character must be held, and further characters must arrive while it is held. The held character must then appear exactly after the sixteenth. The stimulus gets there with sixteen back-to-back arrivals and then two more with no pop, one of which must be dropped. It then drains the store and checks each character in order, along with the head overrun flag before and after the first pop. The timeout is reached by holding `baud_tick` high after a single arrival, and the bench checks the boundary on both sides of the forty-tick limit.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic              ovr;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;

    // Trigger level code to character count (R5).
    function automatic int trig_level(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  rxq_entry_t                 push_ent,
    input  logic                       pop,
    input  logic                       mark_ovr,
    output rxq_entry_t                 head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } st_t;

    st_t        st_d, st_q;
    rxq_entry_t mem [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (int'(p) == DEPTH-1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push) st_d.wr = bump(st_q.wr);
            if (pop)  st_d.rd = bump(st_q.rd);
            case ({push, pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!flush && push)     mem[st_q.wr]     <= push_ent;
        if (!flush && mark_ovr) mem[st_q.rd].ovr <= 1'b1;
    end

    assign head  = mem[st_q.rd];
    assign count = st_q.cnt;
endmodule

// File: rtl/rxq_tout.sv
module rxq_tout #(
    parameter int LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic active,
    input  logic tick,
    output logic fire
);
    localparam int TW = $clog2(LIMIT+1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        fire  = 1'b0;
        if (restart || !active) begin
            cnt_d = '0;
        end else if (tick && int'(cnt_q) < LIMIT) begin
            cnt_d = cnt_q + 1'b1;
            fire  = (int'(cnt_q) == LIMIT-1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_rx_fifo_stat.sv
module uart_rx_fifo_stat
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH          = 16,
    parameter int TICKS_PER_CHAR = 10,
    parameter int TOUT_CHARS     = 4,
    parameter int RTS_W          = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_valid,
    input  logic [DATA_W-1:0]          rx_data,
    input  logic                       rx_brk,
    input  logic                       rx_ferr,
    input  logic                       rx_perr,
    input  logic                       pop,
    input  logic                       baud_tick,
    input  logic [1:0]                 trig_sel,
    input  logic                       rx_ie,
    input  logic                       clr_rdis,
    input  logic                       clr_tout,
    input  logic                       fifo_rst,
    input  logic                       rst_en,
    input  logic                       rts_we,
    input  logic [RTS_W-1:0]           rts_wdata,
    output logic [DATA_W-1:0]          head_data,
    output logic                       st_brk,
    output logic                       st_ferr,
    output logic                       st_perr,
    output logic                       st_ovr,
    output logic                       st_empty,
    output logic [$clog2(DEPTH+1)-1:0] fill_cnt,
    output logic                       st_rdis,
    output logic                       st_tout,
    output logic                       irq,
    output logic                       flow_go
);
    localparam int CW         = $clog2(DEPTH+1);
    localparam int TOUT_LIMIT = TICKS_PER_CHAR * TOUT_CHARS;
    localparam logic [RTS_W-1:0] RTS_RST = '1;

    typedef struct packed {
        logic             hold_vld;
        rxq_entry_t       hold;
        logic             rdis;
        logic             tout;
        logic [RTS_W-1:0] rts_lvl;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    rxq_entry_t head, push_ent, new_ent;
    logic [CW-1:0] cnt;
    logic flush, push, do_pop, mark_ovr, full, empty, fire, level_hit;

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push),
        .push_ent(push_ent), .pop(do_pop), .mark_ovr(mark_ovr),
        .head(head), .count(cnt)
    );

    rxq_tout #(.LIMIT(TOUT_LIMIT)) u_tout (
        .clk(clk), .rst_n(rst_n), .restart(flush | push | do_pop),
        .active(!empty), .tick(baud_tick), .fire(fire)
    );

    always_comb begin
        full      = (int'(cnt) == DEPTH);
        empty     = (cnt == '0);
        flush     = fifo_rst & rst_en;
        do_pop    = pop & !empty & !flush;
        level_hit = int'(cnt) >= trig_level(trig_sel);
        new_ent   = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, ovr: 1'b0, data: rx_data};

        ctl_d    = ctl_q;
        push     = 1'b0;
        push_ent = new_ent;
        mark_ovr = 1'b0;

        if (flush) begin
            ctl_d.hold_vld = 1'b0;
        end else if (do_pop && ctl_q.hold_vld) begin
            push           = 1'b1;
            push_ent       = ctl_q.hold;
            ctl_d.hold_vld = rx_valid;
            ctl_d.hold     = new_ent;
        end else if (rx_valid) begin
            if (!full || do_pop) begin
                push = 1'b1;
            end else begin
                mark_ovr = 1'b1;
                if (!ctl_q.hold_vld) begin
                    ctl_d.hold_vld = 1'b1;
                    ctl_d.hold     = new_ent;
                end
            end
        end

        ctl_d.rdis = (ctl_q.rdis & !clr_rdis) | level_hit;
        ctl_d.tout = (ctl_q.tout & !clr_tout) | fire;
        if (rts_we) ctl_d.rts_lvl = rts_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.rts_lvl <= RTS_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign head_data = empty ? '0 : head.data;
    assign st_brk    = !empty & head.brk;
    assign st_ferr   = !empty & head.ferr;
    assign st_perr   = !empty & head.perr;
    assign st_ovr    = !empty & head.ovr;
    assign st_empty  = empty;
    assign fill_cnt  = cnt;
    assign st_rdis   = ctl_q.rdis;
    assign st_tout   = ctl_q.tout;
    assign irq       = rx_ie & (ctl_q.rdis | ctl_q.tout);
    assign flow_go   = int'(cnt) < int'(ctl_q.rts_lvl);
endmodule

// File: rtl/uart_rx_fifo_stat_chk.sv
module uart_rx_fifo_stat_chk
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rx_valid,
    input logic                       pop,
    input logic [1:0]                 trig_sel,
    input logic                       clr_rdis,
    input logic                       fifo_rst,
    input logic                       rst_en,
    input logic                       st_empty,
    input logic                       st_ovr,
    input logic [$clog2(DEPTH+1)-1:0] fill_cnt,
    input logic                       st_rdis
);
    p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_cnt) <= DEPTH);

    p_push_counts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !pop && !(fifo_rst && rst_en) && int'(fill_cnt) < DEPTH
        |=> int'(fill_cnt) == int'($past(fill_cnt)) + 1);

    p_pop_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_empty && !rx_valid |=> st_empty);

    p_overrun_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !pop && !(fifo_rst && rst_en) && int'(fill_cnt) == DEPTH
        |=> st_ovr && int'(fill_cnt) == DEPTH);

    p_trigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_cnt) >= trig_level(trig_sel) |=> st_rdis);

    p_flush_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst && !rst_en && !rx_valid && !pop |=> $stable(fill_cnt));

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst && rst_en |=> st_empty);
endmodule

bind uart_rx_fifo_stat uart_rx_fifo_stat_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .pop(pop),
    .trig_sel(trig_sel), .clr_rdis(clr_rdis), .fifo_rst(fifo_rst),
    .rst_en(rst_en), .st_empty(st_empty), .st_ovr(st_ovr),
    .fill_cnt(fill_cnt), .st_rdis(st_rdis)
);

// File: tb/uart_rx_fifo_stat_bench.sv
`timescale 1ns/1ps
module uart_rx_fifo_stat_bench;
    localparam int LIMIT = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 0, rx_brk = 0, rx_ferr = 0, rx_perr = 0, pop = 0;
    logic [7:0] rx_data = '0;
    logic       baud_tick = 0, rx_ie = 0, clr_rdis = 0, clr_tout = 0;
    logic       fifo_rst = 0, rst_en = 0, rts_we = 0;
    logic [1:0] trig_sel = 2'b00;
    logic [3:0] rts_wdata = '0;
    logic [7:0] head_data;
    logic       st_brk, st_ferr, st_perr, st_ovr, st_empty, st_rdis, st_tout, irq, flow_go;
    logic [4:0] fill_cnt;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [7:0] sb [$];

    always #2.5 clk = ~clk;

    uart_rx_fifo_stat u_uart_rx_fifo_stat (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_brk(rx_brk), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .pop(pop),
        .baud_tick(baud_tick), .trig_sel(trig_sel), .rx_ie(rx_ie),
        .clr_rdis(clr_rdis), .clr_tout(clr_tout), .fifo_rst(fifo_rst),
        .rst_en(rst_en), .rts_we(rts_we), .rts_wdata(rts_wdata),
        .head_data(head_data), .st_brk(st_brk), .st_ferr(st_ferr),
        .st_perr(st_perr), .st_ovr(st_ovr), .st_empty(st_empty),
        .fill_cnt(fill_cnt), .st_rdis(st_rdis), .st_tout(st_tout),
        .irq(irq), .flow_go(flow_go)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push_char(input logic [7:0] d, input logic b, input logic f, input logic p);
        rx_valid = 1; rx_data = d; rx_brk = b; rx_ferr = f; rx_perr = p;
        @(negedge clk);
        rx_valid = 0; rx_brk = 0; rx_ferr = 0; rx_perr = 0;
    endtask

    task automatic pop_one();
        pop = 1;
        @(negedge clk);
        pop = 0;
    endtask

    task automatic flush_all();
        fifo_rst = 1; rst_en = 1;
        @(negedge clk);
        fifo_rst = 0; rst_en = 0;
        clr_rdis = 1; clr_tout = 1;
        @(negedge clk);
        clr_rdis = 0; clr_tout = 0;
    endtask

    task automatic t_reset();
        chk("R3 empty after reset", st_empty, 1);
        chk("R1 fill after reset", fill_cnt, 0);
        chk("R8 irq after reset", irq, 0);
        chk("R10 flow_go after reset", flow_go, 1);
        chk("R5 rdis after reset", st_rdis, 0);
    endtask

    task automatic t_order_flags();
        flush_all();
        push_char(8'h11, 1, 0, 0);
        push_char(8'h22, 0, 1, 0);
        push_char(8'h33, 0, 0, 1);
        push_char(8'h44, 0, 0, 0);
        chk("R1 fill of four", fill_cnt, 4);
        chk("R2 head 1 data", head_data, 8'h11);
        chk("R2 head 1 brk", st_brk, 1);
        pop_one();
        chk("R2 head 2 data", head_data, 8'h22);
        chk("R2 head 2 ferr", st_ferr, 1);
        chk("R2 head 2 brk", st_brk, 0);
        pop_one();
        chk("R2 head 3 data", head_data, 8'h33);
        chk("R2 head 3 perr", st_perr, 1);
        pop_one();
        chk("R2 head 4 flags", {st_brk, st_ferr, st_perr, st_ovr}, 0);
        chk("R3 not empty", st_empty, 0);
        pop_one();
        chk("R3 empty after drain", st_empty, 1);
        chk("R2 data zero when empty", head_data, 0);
        pop_one();
        chk("R3 pop on empty ignored", fill_cnt, 0);
        chk("R3 still empty", st_empty, 1);
    endtask

    task automatic t_overrun();
        flush_all();
        for (int i = 0; i < 16; i++) push_char(8'(i), 0, 0, 0);
        chk("R4 full", fill_cnt, 16);
        chk("R4 no overrun yet", st_ovr, 0);
        push_char(8'hAA, 0, 0, 0);
        chk("R4 overrun flagged on head", st_ovr, 1);
        chk("R4 fill stays 16", fill_cnt, 16);
        chk("R4 head unchanged", head_data, 0);
        push_char(8'hBB, 0, 0, 0);
        pop_one();
        chk("R4 held char moved in", fill_cnt, 16);
        chk("R4 overrun left with old head", st_ovr, 0);
        for (int i = 1; i < 16; i++) begin
            chk("R4 drain order", head_data, i);
            pop_one();
        end
        chk("R4 held char delivered next", head_data, 8'hAA);
        pop_one();
        chk("R4 dropped char absent", st_empty, 1);
    endtask

    task automatic t_trigger_levels();
        int lv [4] = '{1, 4, 8, 12};
        rx_ie = 1;
        for (int c = 0; c < 4; c++) begin
            trig_sel = 2'(c);
            flush_all();
            for (int i = 0; i < lv[c] - 1; i++) begin
                push_char(8'(8'h40 + i), 0, 0, 0);
                sb.push_back(8'(8'h40 + i));
            end
            idle(1);
            chk("R5 below level", st_rdis, 0);
            chk("R8 irq below level", irq, 0);
            push_char(8'h7E, 0, 0, 0);
            sb.push_back(8'h7E);
            idle(1);
            chk("R5 at level", st_rdis, 1);
            chk("R8 irq at level", irq, 1);
            rx_ie = 0;
            idle(1);
            chk("R8 irq gated", irq, 0);
            rx_ie = 1;
            while (sb.size() > 0) begin
                chk("R5 scoreboard data", head_data, sb.pop_front());
                pop_one();
            end
            clr_rdis = 1;
            @(negedge clk);
            clr_rdis = 0;
            chk("R6 rdis cleared", st_rdis, 0);
        end
        rx_ie = 0;
        trig_sel = 2'b00;
    endtask

    task automatic t_timeout();
        trig_sel = 2'b11;
        flush_all();
        rx_ie = 1;
        push_char(8'h5A, 0, 0, 0);
        baud_tick = 1;
        idle(LIMIT - 1);
        chk("R7 no timeout before limit", st_tout, 0);
        idle(1);
        chk("R7 timeout at limit", st_tout, 1);
        chk("R8 irq from timeout", irq, 1);
        baud_tick = 0;
        clr_tout = 1;
        @(negedge clk);
        clr_tout = 0;
        chk("R6 timeout cleared", st_tout, 0);
        baud_tick = 1;
        idle(LIMIT - 5);
        pop = 1; rx_valid = 1; rx_data = 8'h66;
        @(negedge clk);
        pop = 0; rx_valid = 0;
        idle(LIMIT - 1);
        chk("R7 restart on traffic", st_tout, 0);
        idle(1);
        chk("R7 timeout after restart", st_tout, 1);
        baud_tick = 0;
        rx_ie = 0;
        trig_sel = 2'b00;
    endtask

    task automatic t_flush();
        flush_all();
        push_char(8'h01, 0, 0, 0);
        push_char(8'h02, 0, 0, 0);
        push_char(8'h03, 0, 0, 0);
        fifo_rst = 1;
        @(negedge clk);
        fifo_rst = 0;
        chk("R9 reset without enable ignored", fill_cnt, 3);
        chk("R9 head kept", head_data, 8'h01);
        fifo_rst = 1; rst_en = 1;
        @(negedge clk);
        fifo_rst = 0; rst_en = 0;
        chk("R9 flush empties", fill_cnt, 0);
        chk("R9 flush sets empty", st_empty, 1);
    endtask

    task automatic t_rts();
        flush_all();
        for (int i = 0; i < 14; i++) push_char(8'(i), 0, 0, 0);
        chk("R10 flow at 14", flow_go, 1);
        push_char(8'h0E, 0, 0, 0);
        chk("R10 stop at reset threshold 15", flow_go, 0);
        flush_all();
        rts_we = 1; rts_wdata = 4'd4;
        @(negedge clk);
        rts_we = 0;
        for (int i = 0; i < 3; i++) push_char(8'(i), 0, 0, 0);
        chk("R10 flow at 3", flow_go, 1);
        push_char(8'h03, 0, 0, 0);
        chk("R10 stop at threshold 4", flow_go, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_order_flags();
        t_overrun();
        t_trigger_levels();
        t_timeout();
        t_flush();
        t_rts();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule